// File: doc/BRIEF.md
# Convergent Rounding Right Shifter

This block divides a signed integer by a power of two picked at run time and rounds the quotient to the nearest integer. When the value lies exactly halfway between two integers, it picks the even one. A datapath uses it to drop fractional bits from fixed-point values without the upward bias that plain round-half-up adds over many samples.

The block takes a 32-bit two's-complement operand and a shift count from 0 to 31. It first decides which rounding constant to add, then adds it to the operand sign-extended to twice its width, then shifts the sum arithmetically right. The low 32 bits of the shifted sum are the result. A single register stage captures the result whenever the input is marked valid. The valid flag travels with it, so a new operand can be accepted every cycle.

Top module: `crs_round_shift`

## Requirements
- R1: With a shift count of 0, the captured result equals the operand bit for bit.
- R2: With a shift count n of 1 or more, if the discarded low n bits are less than half of 2^n, the result is the operand divided by 2^n rounded toward minus infinity.
- R3: With n of 1 or more, if the discarded low n bits exceed half of 2^n, the result is that floor quotient plus one.
- R4: With n of 1 or more, if the discarded low n bits equal exactly 2^(n-1), the result is whichever of the floor quotient and the floor quotient plus one is even (result bit 0 is 0).
- R5: Negative operands follow R2 to R4 on their two's-complement bits. At n=1, -3 gives -2 and -5 gives -2.
- R6: The constant is added at double width, so the extreme operands do not wrap. At n=1, 0x7FFFFFFF gives 0x40000000. At n=31, 0x7FFFFFFF gives 1 and 0x80000000 gives -1.
- R7: While reset is high, on the clock edge out_valid and out_data go to 0. After reset, out_valid equals in_valid from one cycle earlier.
- R8: When in_valid is low, out_data keeps its previous value whatever in_data and in_shift carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand and shift count are valid this cycle |
| in_data | input | 32 | Two's-complement operand |
| in_shift | input | 5 | Right shift count, 0 to 31 |
| out_valid | output | 1 | out_data holds a fresh result |
| out_data | output | 32 | Rounded, shifted result |

## Verification
For shift counts 1 to 4, every operand from -64 to 63 is applied. These small counts make every residue, below half, above half and exact tie, appear with both odd and even quotients and both signs. Each of those cases tells the half-to-even branch apart from round-half-up and from truncation. For every shift count from 0 to 31, constructed ties with odd and even quotients, operands one below and one above a tie, and the extreme operands are applied. These show whether the tie test and the half constant follow the run-time position over the full range, and whether the wide addition guards the top bit. Idle cycles with changing inputs check that the output register holds.

// File: rtl/crs_pkg.sv
package crs_pkg;

  // Which rounding constant the adder receives.
  typedef enum logic [1:0] {
    ADD_NONE = 2'd0,  // shift of zero: pass through
    ADD_HALF = 2'd1,  // ordinary half of the dropped weight
    ADD_KEPT = 2'd2   // tie candidate: kept LSB moved to the half position
  } addend_kind_t;

endpackage

// File: rtl/crs_tie_detect.sv
module crs_tie_detect
  import crs_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHIFT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  data,
  input  logic [SHIFT_W-1:0] shift,
  output addend_kind_t       kind
);

  // below_mask[i] set when bit i sits strictly under the half position.
  logic [DATA_W-1:0] below_mask;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_mask
      assign below_mask[gi] = ({1'b0, shift} > (SHIFT_W+1)'(gi + 1));
    end
  endgenerate

  logic low_clear;
  assign low_clear = ~|(data & below_mask);

  always_comb begin
    if (shift == '0)
      kind = ADD_NONE;
    else if (low_clear)
      kind = ADD_KEPT;
    else
      kind = ADD_HALF;
  end

endmodule

// File: rtl/crs_addend_gen.sv
module crs_addend_gen
  import crs_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHIFT_W = $clog2(DATA_W),
  parameter int WIDE_W  = 2 * DATA_W
) (
  input  logic [DATA_W-1:0]  data,
  input  logic [SHIFT_W-1:0] shift,
  input  addend_kind_t       kind,
  output logic [WIDE_W-1:0]  addend
);

  logic [SHIFT_W-1:0] half_pos;
  assign half_pos = shift - SHIFT_W'(1);

  always_comb begin
    addend = '0;
    unique case (kind)
      ADD_HALF: addend = WIDE_W'(1) << half_pos;
      ADD_KEPT: addend = WIDE_W'(data[shift]) << half_pos;
      default:  addend = '0;
    endcase
  end

endmodule

// File: rtl/crs_shift_core.sv
module crs_shift_core #(
  parameter int DATA_W  = 32,
  parameter int SHIFT_W = $clog2(DATA_W),
  parameter int WIDE_W  = 2 * DATA_W
) (
  input  logic [DATA_W-1:0]  data,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [WIDE_W-1:0]  addend,
  output logic [DATA_W-1:0]  result
);

  logic signed [WIDE_W-1:0] extended;
  logic signed [WIDE_W-1:0] total;
  logic signed [WIDE_W-1:0] shifted;

  assign extended = WIDE_W'($signed(data));
  assign total    = extended + $signed(addend);
  assign shifted  = total >>> shift;
  assign result   = shifted[DATA_W-1:0];

endmodule

// File: rtl/crs_round_shift.sv
module crs_round_shift
  import crs_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHIFT_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [SHIFT_W-1:0] in_shift,
  output logic               out_valid,
  output logic [DATA_W-1:0]  out_data
);

  localparam int WIDE_W = 2 * DATA_W;

  addend_kind_t        kind;
  logic [WIDE_W-1:0]   addend;
  logic [DATA_W-1:0]   result;

  crs_tie_detect #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_tie (
    .data  (in_data),
    .shift (in_shift),
    .kind  (kind)
  );

  crs_addend_gen #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W), .WIDE_W(WIDE_W)) u_addend (
    .data   (in_data),
    .shift  (in_shift),
    .kind   (kind),
    .addend (addend)
  );

  crs_shift_core #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W), .WIDE_W(WIDE_W)) u_core (
    .data   (in_data),
    .shift  (in_shift),
    .addend (addend),
    .result (result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid)
        out_data <= result;
    end
  end

endmodule

// File: rtl/crs_round_shift_checker.sv
module crs_round_shift_checker #(
  parameter int DATA_W  = 32,
  parameter int SHIFT_W = $clog2(DATA_W)
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [DATA_W-1:0]  in_data,
  input logic [SHIFT_W-1:0] in_shift,
  input logic               out_valid,
  input logic [DATA_W-1:0]  out_data
);

  logic [DATA_W-1:0] lower_mask;
  logic              tie_now;
  logic signed [DATA_W-1:0] floor_now;

  assign lower_mask = (DATA_W'(1) << (in_shift - SHIFT_W'(1))) - DATA_W'(1);
  assign tie_now    = (in_shift != '0) && in_data[in_shift - SHIFT_W'(1)]
                      && ((in_data & lower_mask) == '0);
  assign floor_now  = $signed(in_data) >>> in_shift;

  // R7
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid) == out_valid || $past(rst));

  // R8
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

  // R1
  a_r1_pass_through: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_shift == '0) |=> out_data == $past(in_data));

  // R2, R3
  a_r3_floor_or_next: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ($signed(out_data) == $past(floor_now))
              || ($signed(out_data) == $past(floor_now) + DATA_W'(1)));

  // R4
  a_r4_tie_even: assert property (@(posedge clk) disable iff (rst)
    (in_valid && tie_now) |=> !out_data[0]);

  // R6
  a_r6_top_shift_range: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_shift == SHIFT_W'(DATA_W - 1)) |=>
      ($signed(out_data) >= -1 && $signed(out_data) <= 1));

endmodule

bind crs_round_shift crs_round_shift_checker #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .in_shift  (in_shift),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/test_crs_round_shift.sv
module test_crs_round_shift;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic [4:0]  in_shift = '0;
  logic        out_valid;
  logic [31:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  crs_round_shift i_crs_round_shift (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_shift  (in_shift),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  function automatic logic [31:0] model(logic [31:0] a, int n);
    longint v, q, r, h;
    v = longint'($signed(a));
    if (n == 0) return a;
    q = v >>> n;
    r = v - (q <<< n);
    h = longint'(1) <<< (n - 1);
    if (r > h || (r == h && q[0])) q = q + 1;
    return q[31:0];
  endfunction

  function automatic string tag_of(logic [31:0] a, int n);
    longint v, q, r, h;
    if (n == 0) return "R1";
    if (a[31]) return "R5";
    v = longint'($signed(a));
    q = v >>> n;
    r = v - (q <<< n);
    h = longint'(1) <<< (n - 1);
    if (r == h) return "R4";
    if (r > h) return "R3";
    return "R2";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one operand, sample result at the next falling edge.
  task automatic run_op(logic [31:0] a, int n, string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = a;
    in_shift = 5'(n);
    @(negedge clk);
    in_valid = 1'b0;
    check("R7", {31'd0, out_valid}, 32'd1);
    check(tag, out_data, model(a, n));
  endtask

  task automatic run_auto(logic [31:0] a, int n);
    run_op(a, n, tag_of(a, n));
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    check("R7", {31'd0, out_valid}, 32'd0);
    check("R7", out_data, 32'd0);
    rst = 1'b0;

    // Named cases
    run_op(32'd12345, 0, "R1");
    run_op(32'h8000_0001, 0, "R1");
    run_op(32'd5, 2, "R2");       // 1.25 -> 1
    run_op(32'd7, 2, "R3");       // 1.75 -> 2
    run_op(32'd6, 2, "R4");       // 1.5 -> 2
    run_op(32'd10, 2, "R4");      // 2.5 -> 2
    run_op(-32'sd3, 1, "R5");     // -1.5 -> -2
    run_op(-32'sd5, 1, "R5");     // -2.5 -> -2
    run_op(32'h7FFF_FFFF, 1, "R6");
    check("R6", out_data, 32'h4000_0000);
    run_op(32'h7FFF_FFFF, 31, "R6");
    check("R6", out_data, 32'd1);
    run_op(32'h8000_0000, 31, "R6");
    check("R6", out_data, 32'hFFFF_FFFF);
    run_op(32'h8000_0000, 1, "R6");

    // Exhaustive small sweep
    for (int n = 1; n <= 4; n++)
      for (int v = -64; v < 64; v++)
        run_auto(32'(v), n);

    // Every shift with constructed patterns
    for (int n = 0; n < 32; n++) begin
      logic [31:0] half;
      half = (n == 0) ? 32'd0 : (32'd1 << (n - 1));
      for (int k = -3; k <= 3; k++) begin
        logic [31:0] base;
        base = 32'(longint'(k) <<< n);
        run_auto(base | half, n);
        run_auto((base | half) + 32'd1, n);
        run_auto((base | half) - 32'd1, n);
      end
      run_auto(32'h7FFF_FFFF, n);
      run_auto(32'h8000_0000, n);
      run_auto(32'hFFFF_FFFF, n);
      run_auto(32'd0, n);
    end

    // Idle cycles hold the output
    run_op(32'd100, 3, "R4");
    held = out_data;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 32'hDEAD_0000 + 32'(i);
      in_shift = 5'(i);
      @(negedge clk);
      check("R8", out_data, held);
      check("R7", {31'd0, out_valid}, 32'd0);
    end

    // Reset mid-stream clears state
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    check("R7", {31'd0, out_valid}, 32'd0);
    check("R7", out_data, 32'd0);
    rst = 1'b0;
    in_valid = 1'b0;

    summary();
  end

endmodule